// File: doc/BRIEF.md
# SPI Receive Staging Buffer

This block holds received SPI frames between the receiver's shift stage and the party that reads them, which is either host software or a DMA engine. A frame that the shifter has finished lands in a one-entry hold stage. While the queue behind it has room, the frame moves on into a small first-in first-out store, and an occupancy count goes up by one. Reads of the pop port take the oldest entry off the queue.

Two status bits report the buffer's state. The overflow bit records that a frame arrived while both the hold stage and the queue were full. A policy input decides what happens to that frame: it can replace the frame waiting in the hold stage, or it can be thrown away. The drain bit says that data is waiting, and it also serves as the DMA request. It is set whenever the queue holds an entry. It is cleared by a DMA-completed pop that empties the queue, or by the host writing a one to it.

Top module: `spi_rx_stage`

## Requirements
- R1: A frame strobed on `frm_valid` enters the hold stage on that edge (`hold_full`=1). On the next edge it moves into the queue if the queue has room, and `fill_count` rises by one.
- R2: When `frm_valid` is high while the hold stage is full, `fill_count` equals DEPTH and no pop takes place in that cycle, `ovf_flag` is 1 after the edge.
- R3: With `ovr_keep_new`=0, a frame that causes an overflow is dropped, and the frame already in the hold stage is the one that later reaches the queue.
- R4: With `ovr_keep_new`=1, a frame that causes an overflow replaces the hold-stage frame, and the replaced frame never reaches the queue.
- R5: `pop_data` shows the oldest queued entry. A pulse on `pop_rd` while the queue is non-empty removes that entry and lowers `fill_count` by one, and entries leave in arrival order.
- R6: A pulse on `pop_rd` while the queue is empty leaves `fill_count` unchanged.
- R7: `drain_flag` is 1 whenever `fill_count` is non-zero, and `dma_req` always equals `drain_flag`.
- R8: `drain_flag` goes to 0 when the queue is empty after a cycle in which `dma_pop_done` was high, or when `clr_drain_w1` is pulsed while the queue stays empty. A pop by the host alone that empties the queue leaves the flag at 1.
- R9: `ovf_flag` stays 1 until `clr_ovf_w1` is pulsed. If a new overflow happens in the same cycle as the clear, the flag stays 1.
- R10: When a hold-stage frame moves into the queue in the same cycle as a pop, both take effect and `fill_count` is unchanged. A full queue accepts the move in that cycle.
- R11: After reset, `fill_count` is 0 and `hold_full`, `ovf_flag`, `drain_flag` and `dma_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovr_keep_new | input | 1 | Overflow policy: 1 replaces the held frame, 0 drops the incoming frame |
| frm_valid | input | 1 | Completed frame strobe from the shifter |
| frm_data | input | FRAME_W | Completed frame contents |
| pop_rd | input | 1 | Pop port read strobe |
| pop_data | output | FRAME_W | Oldest queued entry (unspecified while empty) |
| dma_pop_done | input | 1 | DMA engine reports that its pop read has finished |
| clr_ovf_w1 | input | 1 | Host write of 1 to the overflow bit |
| clr_drain_w1 | input | 1 | Host write of 1 to the drain bit |
| fill_count | output | $clog2(DEPTH+1) | Queue occupancy |
| hold_full | output | 1 | Hold stage holds a frame |
| ovf_flag | output | 1 | Sticky receive overflow |
| drain_flag | output | 1 | Data available flag |
| dma_req | output | 1 | DMA request, equal to the drain flag |

## Verification
The hardest condition to reach is an overflow, because it needs the queue to be completely full and a frame waiting in the hold stage at the moment a further frame arrives. The stimulus gets there by strobing DEPTH+2 frames on consecutive cycles with no pops, so the last strobe meets a full queue and a full hold stage. Each policy setting is run once. The bench then pops every entry and compares the order, which shows whether the held frame was kept or replaced. A pop against a full queue with a waiting hold frame then covers the case where a move and a pop happen in the same cycle.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

   // what the hold stage does with an arriving frame
   typedef enum logic [1:0] {
      HOLD_IDLE    = 2'd0,
      HOLD_LOAD    = 2'd1,
      HOLD_DROP    = 2'd2,
      HOLD_REPLACE = 2'd3
   } hold_act_e;

   function automatic int unsigned ptr_width(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/rx_hold_stage.sv
module rx_hold_stage
   import spi_rx_pkg::*;
#(
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               keep_new,
   input  logic               in_valid,
   input  logic [FRAME_W-1:0] in_data,
   input  logic               room,
   output logic               hold_valid,
   output logic [FRAME_W-1:0] hold_data,
   output logic               move,
   output logic               ovf_event
);

   hold_act_e act;

   assign move      = hold_valid & room;
   assign ovf_event = in_valid & hold_valid & ~room;

   always_comb begin
      act = HOLD_IDLE;
      if (in_valid) begin
         if (!ovf_event)
            act = HOLD_LOAD;
         else if (keep_new)
            act = HOLD_REPLACE;
         else
            act = HOLD_DROP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
      end else begin
         case (act)
            HOLD_LOAD, HOLD_REPLACE: begin
               hold_valid <= 1'b1;
               hold_data  <= in_data;
            end
            HOLD_DROP: begin
               hold_valid <= 1'b1;
            end
            default: begin
               if (move)
                  hold_valid <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
   import spi_rx_pkg::*;
#(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned DEPTH   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [FRAME_W-1:0]          push_data,
   input  logic                        pop_req,
   output logic                        pop_ok,
   output logic [FRAME_W-1:0]          head_data,
   output logic                        full,
   output logic [cnt_width(DEPTH)-1:0] count,
   output logic [cnt_width(DEPTH)-1:0] count_nxt
);

   localparam int unsigned PTR_W = ptr_width(DEPTH);
   localparam int unsigned CNT_W = cnt_width(DEPTH);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [FRAME_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   wr_ptr, rd_ptr, wr_ptr_inc, rd_ptr_inc;

   assign full      = (count == FULL_CNT);
   assign pop_ok    = pop_req & (count != '0);
   assign head_data = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_ptr_inc = wr_ptr + 1'b1;
         assign rd_ptr_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign wr_ptr_inc = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_inc = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_comb begin
      count_nxt = count;
      case ({push, pop_ok})
         2'b10:   count_nxt = count + 1'b1;
         2'b01:   count_nxt = count - 1'b1;
         default: count_nxt = count;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         count <= count_nxt;
         if (push)
            wr_ptr <= wr_ptr_inc;
         if (pop_ok)
            rd_ptr <= rd_ptr_inc;
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(i))
               mem[i] <= push_data;
         end
      end
   endgenerate

endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf_event,
   input  logic             clr_ovf,
   input  logic [CNT_W-1:0] count_nxt,
   input  logic             dma_done,
   input  logic             clr_drain,
   output logic             ovf_q,
   output logic             drain_q
);

   logic will_hold, drain_clear;

   assign will_hold   = (count_nxt != '0);
   assign drain_clear = dma_done | clr_drain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q   <= 1'b0;
         drain_q <= 1'b0;
      end else begin
         if (ovf_event)
            ovf_q <= 1'b1;
         else if (clr_ovf)
            ovf_q <= 1'b0;

         if (will_hold)
            drain_q <= 1'b1;
         else if (drain_clear)
            drain_q <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_rx_stage.sv
module spi_rx_stage
   import spi_rx_pkg::*;
#(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned DEPTH   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ovr_keep_new,
   input  logic                        frm_valid,
   input  logic [FRAME_W-1:0]          frm_data,
   input  logic                        pop_rd,
   output logic [FRAME_W-1:0]          pop_data,
   input  logic                        dma_pop_done,
   input  logic                        clr_ovf_w1,
   input  logic                        clr_drain_w1,
   output logic [$clog2(DEPTH+1)-1:0]  fill_count,
   output logic                        hold_full,
   output logic                        ovf_flag,
   output logic                        drain_flag,
   output logic                        dma_req
);

   localparam int unsigned CNT_W = cnt_width(DEPTH);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("spi_rx_stage: DEPTH must be at least 1");
      end
      if (FRAME_W < 1) begin : g_bad_width
         $error("spi_rx_stage: FRAME_W must be at least 1");
      end
   endgenerate

   logic               room, move, ovf_event, pop_ok, q_full;
   logic               hold_valid;
   logic [FRAME_W-1:0] hold_data;
   logic [CNT_W-1:0]   count_nxt;

   // a full queue can still take the held frame if a pop frees a slot
   assign room = ~q_full | pop_ok;

   rx_hold_stage #(.FRAME_W(FRAME_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .keep_new   (ovr_keep_new),
      .in_valid   (frm_valid),
      .in_data    (frm_data),
      .room       (room),
      .hold_valid (hold_valid),
      .hold_data  (hold_data),
      .move       (move),
      .ovf_event  (ovf_event)
   );

   rx_fifo_store #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (move),
      .push_data (hold_data),
      .pop_req   (pop_rd),
      .pop_ok    (pop_ok),
      .head_data (pop_data),
      .full      (q_full),
      .count     (fill_count),
      .count_nxt (count_nxt)
   );

   rx_status_flags #(.CNT_W(CNT_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovf_event (ovf_event),
      .clr_ovf   (clr_ovf_w1),
      .count_nxt (count_nxt),
      .dma_done  (dma_pop_done),
      .clr_drain (clr_drain_w1),
      .ovf_q     (ovf_flag),
      .drain_q   (drain_flag)
   );

   assign hold_full = hold_valid;
   assign dma_req   = drain_flag;

endmodule

// File: rtl/spi_rx_stage_checker.sv
module spi_rx_stage_checker #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frm_valid,
   input logic             pop_rd,
   input logic             clr_ovf_w1,
   input logic [CNT_W-1:0] fill_count,
   input logic             hold_full,
   input logic             ovf_flag,
   input logic             drain_flag,
   input logic             dma_req
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= FULL_CNT);

   assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && hold_full && fill_count == FULL_CNT && !pop_rd) |=> ovf_flag);

   assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_rd && fill_count == '0 && !hold_full) |=> fill_count == '0);

   assert_drain_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_count != '0) |-> drain_flag);

   assert_dma_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req == drain_flag);

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_ovf_w1) |=> ovf_flag);

   assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_rd && hold_full && fill_count == FULL_CNT) |=> fill_count == FULL_CNT);

endmodule

bind spi_rx_stage spi_rx_stage_checker #(
   .DEPTH (DEPTH),
   .CNT_W ($clog2(DEPTH+1))
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_valid  (frm_valid),
   .pop_rd     (pop_rd),
   .clr_ovf_w1 (clr_ovf_w1),
   .fill_count (fill_count),
   .hold_full  (hold_full),
   .ovf_flag   (ovf_flag),
   .drain_flag (drain_flag),
   .dma_req    (dma_req)
);

// File: tb/spi_rx_stage_bench.sv
`timescale 1ns/1ps
module spi_rx_stage_bench;

   localparam int unsigned FRAME_W = 16;
   localparam int unsigned DEPTH   = 4;
   localparam int unsigned CNT_W   = $clog2(DEPTH+1);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               ovr_keep_new = 1'b0;
   logic               frm_valid = 1'b0;
   logic [FRAME_W-1:0] frm_data = '0;
   logic               pop_rd = 1'b0;
   logic [FRAME_W-1:0] pop_data;
   logic               dma_pop_done = 1'b0;
   logic               clr_ovf_w1 = 1'b0;
   logic               clr_drain_w1 = 1'b0;
   logic [CNT_W-1:0]   fill_count;
   logic               hold_full, ovf_flag, drain_flag, dma_req;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   spi_rx_stage #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_spi_rx_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .ovr_keep_new (ovr_keep_new),
      .frm_valid    (frm_valid),
      .frm_data     (frm_data),
      .pop_rd       (pop_rd),
      .pop_data     (pop_data),
      .dma_pop_done (dma_pop_done),
      .clr_ovf_w1   (clr_ovf_w1),
      .clr_drain_w1 (clr_drain_w1),
      .fill_count   (fill_count),
      .hold_full    (hold_full),
      .ovf_flag     (ovf_flag),
      .drain_flag   (drain_flag),
      .dma_req      (dma_req)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // inputs change at negedge; one posedge passes; return at next negedge
   task automatic cycle();
      @(negedge clk);
      frm_valid    = 1'b0;
      pop_rd       = 1'b0;
      dma_pop_done = 1'b0;
      clr_ovf_w1   = 1'b0;
      clr_drain_w1 = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic send(input logic [FRAME_W-1:0] d);
      frm_valid = 1'b1;
      frm_data  = d;
      cycle();
   endtask

   task automatic pop_expect(input string req, input logic [FRAME_W-1:0] d);
      check(req, "pop_data", pop_data, d);
      pop_rd = 1'b1;
      cycle();
   endtask

   task automatic t_reset();
      check("R11", "fill_count", fill_count, 0);
      check("R11", "hold_full", hold_full, 0);
      check("R11", "ovf_flag", ovf_flag, 0);
      check("R11", "drain_flag", drain_flag, 0);
      check("R11", "dma_req", dma_req, 0);
   endtask

   task automatic t_single();
      send(16'hA5A5);
      check("R1", "hold_full after strobe", hold_full, 1);
      check("R1", "fill_count before move", fill_count, 0);
      cycle();
      check("R1", "hold_full after move", hold_full, 0);
      check("R1", "fill_count after move", fill_count, 1);
      check("R7", "drain_flag", drain_flag, 1);
      check("R7", "dma_req", dma_req, 1);
      pop_expect("R5", 16'hA5A5);
      check("R5", "fill_count after pop", fill_count, 0);
      check("R8", "drain stays after host pop", drain_flag, 1);
      clr_drain_w1 = 1'b1;
      cycle();
      check("R8", "drain after w1c", drain_flag, 0);
      check("R8", "dma_req after w1c", dma_req, 0);
   endtask

   task automatic t_empty_pop();
      pop_rd = 1'b1;
      cycle();
      check("R6", "fill_count after empty pop", fill_count, 0);
      check("R6", "drain after empty pop", drain_flag, 0);
   endtask

   task automatic t_overflow(input logic keep);
      ovr_keep_new = keep;
      for (int i = 0; i < DEPTH + 2; i++) send(16'h1000 + FRAME_W'(i));
      check("R2", "ovf_flag", ovf_flag, 1);
      check("R2", "fill_count full", fill_count, DEPTH);
      check("R2", "hold_full", hold_full, 1);
      idle(3);
      check("R9", "ovf sticky", ovf_flag, 1);
      for (int i = 0; i < DEPTH; i++)
         pop_expect("R5", 16'h1000 + FRAME_W'(i));
      if (keep)
         pop_expect("R4", 16'h1000 + FRAME_W'(DEPTH + 1));
      else
         pop_expect("R3", 16'h1000 + FRAME_W'(DEPTH));
      check(keep ? "R4" : "R3", "fill_count drained", fill_count, 0);
      check("R3", "hold empty", hold_full, 0);
      clr_ovf_w1 = 1'b1;
      cycle();
      check("R9", "ovf after w1c", ovf_flag, 0);
      clr_drain_w1 = 1'b1;
      cycle();
      ovr_keep_new = 1'b0;
   endtask

   task automatic t_full_pop_move();
      for (int i = 0; i < DEPTH + 1; i++) send(16'h2000 + FRAME_W'(i));
      check("R10", "fill_count full", fill_count, DEPTH);
      check("R10", "hold_full", hold_full, 1);
      check("R2", "no overflow", ovf_flag, 0);
      pop_expect("R10", 16'h2000);
      check("R10", "fill_count stays full", fill_count, DEPTH);
      check("R10", "hold emptied", hold_full, 0);
      for (int i = 1; i <= DEPTH; i++)
         pop_expect("R5", 16'h2000 + FRAME_W'(i));
      check("R5", "fill_count", fill_count, 0);
      clr_drain_w1 = 1'b1;
      cycle();
   endtask

   task automatic t_move_and_pop();
      send(16'h3001);
      cycle();
      send(16'h3002);
      check("R10", "fill_count before", fill_count, 1);
      pop_expect("R10", 16'h3001);
      check("R10", "fill_count unchanged", fill_count, 1);
      check("R10", "head is second", pop_data, 16'h3002);
      pop_rd = 1'b1;
      dma_pop_done = 1'b1;
      cycle();
      check("R8", "fill_count", fill_count, 0);
      check("R8", "drain after dma pop", drain_flag, 0);
   endtask

   task automatic t_dma_nonempty();
      send(16'h4001);
      cycle();
      dma_pop_done = 1'b1;
      clr_drain_w1 = 1'b1;
      cycle();
      check("R7", "drain held while non-empty", drain_flag, 1);
      check("R7", "dma_req held", dma_req, 1);
      pop_rd = 1'b1;
      cycle();
      check("R8", "drain after host pop", drain_flag, 1);
      dma_pop_done = 1'b1;
      cycle();
      check("R8", "drain after dma done on empty", drain_flag, 0);
   endtask

   task automatic t_ovf_clear_race();
      for (int i = 0; i < DEPTH + 2; i++) send(16'h5000 + FRAME_W'(i));
      frm_valid  = 1'b1;
      frm_data   = 16'h5FFF;
      clr_ovf_w1 = 1'b1;
      cycle();
      check("R9", "set wins over clear", ovf_flag, 1);
      clr_ovf_w1 = 1'b1;
      cycle();
      check("R9", "cleared", ovf_flag, 0);
      for (int i = 0; i < DEPTH + 1; i++) begin
         pop_rd = 1'b1;
         cycle();
      end
      check("R6", "all drained", fill_count, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      idle(2);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_single();
      t_empty_pop();
      t_overflow(1'b0);
      t_overflow(1'b1);
      t_full_pop_move();
      t_move_and_pop();
      t_dma_nonempty();
      t_ovf_clear_race();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule